// File: doc/BRIEF.md
# Almost-Inverse Inverter for GF(2^89)

This block computes the multiplicative inverse of a nonzero element of the binary field GF(2^89). The operand is held in polynomial basis, and the field is reduced by the trinomial u^89 + u^38 + 1. Both exponents are parameters, so any irreducible trinomial u^M + u^T + 1 can be used. A caller presents an operand together with a one-cycle start strobe. Some cycles later a one-cycle done strobe appears, and the inverse is placed on the result port. A zero operand has no inverse. For a zero operand the block raises an error flag and completes at once.

The work is split into two phases.

- **First phase.** The block runs the almost-inverse iteration on four working polynomials. Each working polynomial has its degree held in a register, so choosing between swap and add needs only a compare of two small numbers. When the low end of the active polynomial is even, up to two trailing zero bits are removed in one cycle. The phase ends with a value b and a count k such that b·a = u^k.
- **Second phase.** A fix-up sequencer divides b by u^8 in each cycle while k is at least 8. It then divides by u one step at a time until k reaches zero.

Top module: `gf_almost_inverse`

## Requirements
- R1: For every nonzero operand a, the result r on the done cycle satisfies a·r = 1 modulo u^M + u^T + 1. The defaults are M = 89 and T = 38. Bit i of operand and result is the coefficient of u^i.
- R2: A start with operand zero gives done high after the very edge that samples start, with err = 1 and result = 0.
- R3: A start with a nonzero operand gives err = 0 on its done cycle.
- R4: After reset, done, err and result are all zero. Result and err change only on a cycle in which done is high. Done lasts one cycle for each accepted start.
- R5: A start raised while an inversion is in progress is ignored. The running operation delivers the inverse of the operand it accepted, and no extra done follows.
- R6: For an operand u^j with 0 ≤ j < M, done first shows high after edge number 3 + ceil(j/2) + floor(j/8) + (j mod 8). Edge number 1 is the edge that accepts start. This count reflects two zero bits stripped per cycle and eight factors of u removed per fix-up cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an inversion; sampled only while idle |
| operand | input | M | Field element to invert |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Operand was zero; valid from done onward |
| result | output | M | Inverse of the operand, held until the next done |

## Verification
The bench builds the block twice.

- **Default build (M = 89, T = 38).** This copy is driven with random operands, the all-ones pattern and a set of powers of u up to u^88. It also receives a zero operand and a start raised while busy. The powers of u give an exact, closed-form cycle count, and that count exercises both the two-bit strip and the divide-by-u^8 path.
- **Small build (M = 7, T = 1).** The trinomial u^7 + u + 1 is small enough that all 127 nonzero operands and the zero operand are swept one by one. This sweep reaches every swap/add ordering the iteration can take in that field.

// File: rtl/gf_ai_pkg.sv
package gf_ai_pkg;

  localparam int GW = 128;
  typedef logic [GW-1:0] gf_vec_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ITER, ST_FIX} ai_state_e;

  // multiply by u modulo u^m + u^t + 1
  function automatic gf_vec_t gf_mulx(gf_vec_t x, int m, int t);
    gf_vec_t y;
    y = x << 1;
    if (y[m]) begin
      y[m] = 1'b0;
      y[t] = ~y[t];
      y[0] = ~y[0];
    end
    return y;
  endfunction

  // divide by u modulo u^m + u^t + 1
  function automatic gf_vec_t gf_divx(gf_vec_t x, int m, int t);
    gf_vec_t y;
    y = x;
    if (y[0]) begin
      y[0] = 1'b0;
      y[t] = ~y[t];
      y[m] = ~y[m];
    end
    return y >> 1;
  endfunction

  // divide by u^n, n up to 16
  function automatic gf_vec_t gf_divn(gf_vec_t x, int n, int m, int t);
    gf_vec_t y;
    y = x;
    for (int i = 0; i < 16; i++) begin
      if (i < n) y = gf_divx(y, m, t);
    end
    return y;
  endfunction

  // index of highest set bit, -1 for zero
  function automatic int gf_deg(gf_vec_t x);
    int d;
    d = -1;
    for (int i = 0; i < GW; i++) begin
      if (x[i]) d = i;
    end
    return d;
  endfunction

endpackage

// File: rtl/gf_ai_iter.sv
module gf_ai_iter
  import gf_ai_pkg::*;
#(
  parameter int M  = 89,
  parameter int T  = 38,
  parameter int KW = $clog2(2*M+1)+1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [M-1:0]  opnd,
  output logic          fin,
  output logic [M-1:0]  b_out,
  output logic [KW-1:0] k_out
);

  localparam int W  = M + 1;
  localparam int DW = $clog2(W) + 1;
  localparam logic [W-1:0] FPOLY = (W'(1) << M) | (W'(1) << T) | W'(1);

  logic [W-1:0]  u, v, u_n, v_n;
  logic [M-1:0]  b, c, b_n, c_n;
  logic [DW-1:0] deg_u, deg_v, deg_u_n, deg_v_n;
  logic [KW-1:0] k, k_n;

  // named events for assertions
  logic strip_ev, strip2_ev, add_ev, swap_ev;

  assign fin      = (deg_u == '0);
  assign strip_ev  = run && !fin && !u[0];
  assign strip2_ev = strip_ev && !u[1];
  assign add_ev    = run && !fin && u[0];
  assign swap_ev   = add_ev && (deg_u < deg_v);

  always_comb begin
    u_n = u; v_n = v; b_n = b; c_n = c;
    deg_u_n = deg_u; deg_v_n = deg_v; k_n = k;
    if (!u[0]) begin
      if (!u[1]) begin
        u_n     = u >> 2;
        deg_u_n = deg_u - DW'(2);
        c_n     = M'(gf_mulx(gf_mulx(GW'(c), M, T), M, T));
        k_n     = k + KW'(2);
      end else begin
        u_n     = u >> 1;
        deg_u_n = deg_u - DW'(1);
        c_n     = M'(gf_mulx(GW'(c), M, T));
        k_n     = k + KW'(1);
      end
    end else if (deg_u != '0) begin
      u_n = u ^ v;
      b_n = b ^ c;
      if (deg_u < deg_v) begin
        v_n     = u;
        c_n     = b;
        deg_u_n = deg_v;
        deg_v_n = deg_u;
      end else if (deg_u == deg_v) begin
        deg_u_n = DW'(gf_deg(GW'(u ^ v)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      u <= '0; v <= '0; b <= '0; c <= '0;
      deg_u <= '0; deg_v <= '0; k <= '0;
    end else if (load) begin
      u     <= W'(opnd);
      v     <= FPOLY;
      b     <= M'(1);
      c     <= '0;
      deg_u <= DW'(gf_deg(GW'(opnd)));
      deg_v <= DW'(M);
      k     <= '0;
    end else if (run && !fin) begin
      u <= u_n; v <= v_n; b <= b_n; c <= c_n;
      deg_u <= deg_u_n; deg_v <= deg_v_n; k <= k_n;
    end
  end

  assign b_out = b;
  assign k_out = k;

  // the working polynomial never collapses to zero
  assert_u_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (u != '0));
  // the tracked degree points at the leading one
  assert_deg_track_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (u[deg_u] && v[deg_v]));
  // a two-bit strip advances the exponent count by two
  assert_strip_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strip2_ev |=> (k == $past(k) + KW'(2)));
  // exponent count never exceeds 2M
  assert_k_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (k <= KW'(2*M)));
  // after an add, the active polynomial is even
  assert_add_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
    add_ev |=> !u[0]);

endmodule

// File: rtl/gf_ai_fix.sv
module gf_ai_fix
  import gf_ai_pkg::*;
#(
  parameter int M        = 89,
  parameter int T        = 38,
  parameter int KW       = $clog2(2*M+1)+1,
  parameter int FIX_STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [M-1:0]  b_in,
  input  logic [KW-1:0] k_in,
  output logic          fin,
  output logic [M-1:0]  r_out
);

  logic [M-1:0]  r, r_n;
  logic [KW-1:0] k, k_n;
  logic          wide_ev;

  assign fin     = (k == '0);
  assign wide_ev = run && !fin && (k >= KW'(FIX_STEP));

  always_comb begin
    if (k >= KW'(FIX_STEP)) begin
      r_n = M'(gf_divn(GW'(r), FIX_STEP, M, T));
      k_n = k - KW'(FIX_STEP);
    end else begin
      r_n = M'(gf_divx(GW'(r), M, T));
      k_n = k - KW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r <= '0;
      k <= '0;
    end else if (load) begin
      r <= b_in;
      k <= k_in;
    end else if (run && !fin) begin
      r <= r_n;
      k <= k_n;
    end
  end

  assign r_out = r;

  // every active fix-up cycle removes at least one factor of u
  assert_fix_progress_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fin) |=> (k < $past(k)));
  // a wide step removes exactly FIX_STEP factors
  assert_fix_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wide_ev |=> (k + KW'(FIX_STEP) == $past(k)));

endmodule

// File: rtl/gf_almost_inverse.sv
module gf_almost_inverse
  import gf_ai_pkg::*;
#(
  parameter int M        = 89,
  parameter int T        = 38,
  parameter int FIX_STEP = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] operand,
  output logic         done,
  output logic         err,
  output logic [M-1:0] result
);

  localparam int KW = $clog2(2*M+1) + 1;

  ai_state_e     st;
  logic          opnd_zero, accept_ev;
  logic          it_load, it_run, it_fin;
  logic          fx_load, fx_run, fx_fin;
  logic [M-1:0]  it_b, fx_r;
  logic [KW-1:0] it_k;

  assign opnd_zero = (operand == '0);
  assign accept_ev = (st == ST_IDLE) && start;
  assign it_load   = accept_ev && !opnd_zero;
  assign it_run    = (st == ST_ITER);
  assign fx_load   = it_run && it_fin;
  assign fx_run    = (st == ST_FIX);

  gf_ai_iter #(.M(M), .T(T), .KW(KW)) iter_i (
    .clk(clk), .rst_n(rst_n), .load(it_load), .run(it_run),
    .opnd(operand), .fin(it_fin), .b_out(it_b), .k_out(it_k)
  );

  gf_ai_fix #(.M(M), .T(T), .KW(KW), .FIX_STEP(FIX_STEP)) fix_i (
    .clk(clk), .rst_n(rst_n), .load(fx_load), .run(fx_run),
    .b_in(it_b), .k_in(it_k), .fin(fx_fin), .r_out(fx_r)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      done   <= 1'b0;
      err    <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (opnd_zero) begin
              done   <= 1'b1;
              err    <= 1'b1;
              result <= '0;
            end else begin
              st <= ST_ITER;
            end
          end
        end
        ST_ITER: if (it_fin) st <= ST_FIX;
        ST_FIX: begin
          if (fx_fin) begin
            st     <= ST_IDLE;
            done   <= 1'b1;
            err    <= 1'b0;
            result <= fx_r;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // zero operand reports zero with the error flag
  assert_zero_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (result == '0));
  // completion of fix-up yields a clean done
  assert_clean_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fx_run && fx_fin) |=> (done && !err));
  // outputs hold while idle with no request
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_IDLE) && !start) |=> ($stable(result) && $stable(err) && !done));
  // a busy block never starts a new iteration
  assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |-> !it_load);

endmodule

// File: tb/gf_almost_inverse_tb_top.sv
`timescale 1ns/1ps
module gf_almost_inverse_tb_top;

  localparam int BM = 89, BT = 38;
  localparam int SM = 7,  ST = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          b_start = 1'b0, s_start = 1'b0;
  logic [BM-1:0] b_op = '0, b_res;
  logic [SM-1:0] s_op = '0, s_res;
  logic          b_done, b_err, s_done, s_err;

  gf_almost_inverse #(.M(BM), .T(BT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(b_start), .operand(b_op),
    .done(b_done), .err(b_err), .result(b_res)
  );

  gf_almost_inverse #(.M(SM), .T(ST)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .start(s_start), .operand(s_op),
    .done(s_done), .err(s_err), .result(s_res)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  // schoolbook product then reduction from the top
  function automatic logic [127:0] ref_mul(logic [127:0] a, logic [127:0] b, int m, int t);
    logic [255:0] p;
    p = '0;
    for (int i = 0; i < m; i++) if (b[i]) p = p ^ (256'(a) << i);
    for (int i = 2*m; i >= m; i--) begin
      if (p[i]) begin
        p[i] = 1'b0;
        p[i-m+t] = ~p[i-m+t];
        p[i-m] = ~p[i-m];
      end
    end
    return p[127:0];
  endfunction

  function automatic int ref_lat(int j);
    return 3 + (j + 1) / 2 + j / 8 + j % 8;
  endfunction

  task automatic run_big(input logic [BM-1:0] op, output logic [BM-1:0] res,
                         output logic ef, output int cyc);
    @(negedge clk);
    b_op = op; b_start = 1'b1; cyc = 0;
    while (1) begin
      @(posedge clk); cyc++;
      @(negedge clk); b_start = 1'b0;
      if (b_done) break;
      if (cyc > 4000) begin chk("timeout big", 0, 1); break; end
    end
    res = b_res; ef = b_err;
  endtask

  task automatic run_small(input logic [SM-1:0] op, output logic [SM-1:0] res,
                           output logic ef, output int cyc);
    @(negedge clk);
    s_op = op; s_start = 1'b1; cyc = 0;
    while (1) begin
      @(posedge clk); cyc++;
      @(negedge clk); s_start = 1'b0;
      if (s_done) break;
      if (cyc > 1000) begin chk("timeout small", 0, 1); break; end
    end
    res = s_res; ef = s_err;
  endtask

  initial begin
    #900000;
    $display("FAIL watchdog: actual hung expected completion");
    n_errors++;
    finish_run();
  end

  initial begin
    logic [BM-1:0] br;
    logic [SM-1:0] sr;
    logic ef;
    int cyc;
    int extra;
    int pw[12] = '{0, 1, 2, 3, 7, 8, 9, 15, 16, 38, 64, 88};

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R4: reset state
    chk("R4 reset done", 128'(b_done), 0);
    chk("R4 reset err", 128'(b_err), 0);
    chk("R4 reset result", 128'(b_res), 0);

    // R2: zero operand, small and big
    run_big('0, br, ef, cyc);
    chk("R2 zero latency", 128'(cyc), 1);
    chk("R2 zero err", 128'(ef), 1);
    chk("R2 zero result", 128'(br), 0);
    @(negedge clk);
    // R4: one-cycle done, outputs hold
    chk("R4 done pulse", 128'(b_done), 0);
    chk("R4 err hold", 128'(b_err), 1);
    chk("R4 result hold", 128'(b_res), 0);
    run_small('0, sr, ef, cyc);
    chk("R2 zero small err", 128'(ef), 1);

    // R1/R3: exhaustive sweep of the small field
    for (int a = 1; a < (1 << SM); a++) begin
      run_small(SM'(a), sr, ef, cyc);
      chk("R1 small inverse", ref_mul(128'(a), 128'(sr), SM, ST), 1);
      chk("R3 small err", 128'(ef), 0);
    end

    // R6: latency for powers of u, small field
    for (int j = 0; j < SM; j++) begin
      run_small(SM'(1) << j, sr, ef, cyc);
      chk("R6 small power latency", 128'(cyc), 128'(ref_lat(j)));
    end

    // R6/R1: powers of u in the default field, including 1 and u^88
    foreach (pw[i]) begin
      run_big(BM'(1) << pw[i], br, ef, cyc);
      chk("R6 power latency", 128'(cyc), 128'(ref_lat(pw[i])));
      chk("R1 power inverse", ref_mul(128'(BM'(1) << pw[i]), 128'(br), BM, BT), 1);
      chk("R3 power err", 128'(ef), 0);
    end

    // R1: all ones and random operands
    run_big('1, br, ef, cyc);
    chk("R1 all-ones inverse", ref_mul(128'({BM{1'b1}}), 128'(br), BM, BT), 1);
    for (int n = 0; n < 150; n++) begin
      logic [BM-1:0] a;
      a = BM'({$urandom(), $urandom(), $urandom()});
      if (a == '0) a = BM'(5);
      run_big(a, br, ef, cyc);
      chk("R1 random inverse", ref_mul(128'(a), 128'(br), BM, BT), 1);
    end

    // R5: start while busy is ignored
    begin
      logic [BM-1:0] a1, a2;
      a1 = BM'({$urandom(), $urandom(), $urandom()}) | BM'(3) << 60;
      a2 = a1 ^ BM'(6);
      @(negedge clk); b_op = a1; b_start = 1'b1;
      @(posedge clk);
      @(negedge clk); b_op = a2;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk); b_start = 1'b0;
      cyc = 0;
      while (!b_done && cyc < 4000) begin @(negedge clk); cyc++; end
      chk("R5 busy result", ref_mul(128'(a1), 128'(b_res), BM, BT), 1);
      extra = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (b_done) extra++;
      end
      chk("R5 no extra done", 128'(extra), 0);
    end

    finish_run();
  end

endmodule